// File: doc/BRIEF.md
# Parallel multi-digit BCD adder

This block adds two unsigned packed-BCD operands of `DIGITS` decimal digits together with a single decimal carry-in. It returns the packed-BCD sum and the decimal carry-out of the top digit. It is purely combinational, with no clock and no reset. It is meant for the decimal datapath of a larger arithmetic unit, and a caller that wants registered results adds its own flops around it.

Every digit slice first forms a plain 4-bit binary sum of its two operand digits. This step does not wait on any decimal carry, so all slices do it in parallel. From that sum, each slice derives two flags. The first, a carry-independent decimal generate flag, is set when the slice is sure to carry. The second, a propagate flag, is set when the slice carries if a carry arrives. A chain of 3-input majority functions, one per digit, then resolves every decimal carry. Last, each slice adds the +6 correction and its incoming carry to its binary sum.

Top module: `bcd_par_adder`

## Requirements
- R1: `sum_o` equals (A + B + `cin_i`) mod 10^DIGITS in packed BCD. Here A and B are the decimal values of `a_i` and `b_i`, and digit k occupies bits [4k+3:4k], with the least significant digit in bits [3:0].
- R2: `cout_o` is 1 exactly when A + B + `cin_i` >= 10^DIGITS.
- R3: A digit's generate flag is 1 exactly when the 5-bit binary sum of its two operand digits is 10 or more. This includes sums of 16 and above, which set the binary carry.
- R4: A digit's propagate flag is 1 exactly when that 5-bit binary sum is 9 or more, so generate implies propagate.
- R5: A digit's decimal carry-out is majority(generate, propagate, carry into the digit). It equals 1 exactly when the two operand digits plus the incoming carry reach 10 or more.
- R6: Each output digit is (binary sum + 6·c + incoming carry) mod 16, where c is that digit's decimal carry-out. The bit carried out of this addition is dropped.
- R7: Every output digit lies in 0..9 whenever both operand digits lie in 0..9.
- R8: The carry into digit 0 is `cin_i`. A 9 in every digit plus `cin_i`=1 carries through all digits, giving an all-zero sum and `cout_o`=1.
- R9: The outputs follow any input change within the same evaluation, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*DIGITS | Operand A, packed BCD |
| b_i | input | 4*DIGITS | Operand B, packed BCD |
| cin_i | input | 1 | Decimal carry-in to digit 0 |
| sum_o | output | 4*DIGITS | Packed-BCD sum |
| cout_o | output | 1 | Decimal carry-out of the top digit |

## Verification
Directed patterns target each carry source. Digit pairs of 9+9 set the binary carry, and pairs of 5+5 give a binary sum of 10 or more without it. Both of these must generate. Pairs of 4+5 sit exactly at a binary sum of 9, so they carry only when a carry arrives. Sweeping the carry-in on these pairs separates generate from propagate. An all-9s operand with a carry-in of 1 sends one carry through every majority stage. The same operand with no carry-in shows that a propagate-only chain never carries by itself. Random valid-BCD operands with random carry-in, compared against integer arithmetic, cover mixed chains of all three kinds.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction
endpackage

// File: rtl/bcd_digit_pre.sv
module bcd_digit_pre
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [DIGIT_W-1:0] bsum_o,
  output logic               gen_o,
  output logic               prop_o
);
  logic bcarry;

  assign {bcarry, bsum_o} = {1'b0, a_i} + {1'b0, b_i};
  assign gen_o  = bcarry | (bsum_o[3] & bsum_o[2]) | (bsum_o[3] & bsum_o[1]);
  assign prop_o = gen_o | (bsum_o[3] & bsum_o[0]);

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      p_gen_ge10_r3: assert (gen_o == (({1'b0, a_i} + {1'b0, b_i}) >= 5'd10))
        else $error("generate flag mismatch");
      p_prop_ge9_r4: assert (prop_o == (({1'b0, a_i} + {1'b0, b_i}) >= 5'd9))
        else $error("propagate flag mismatch");
    end
  end
endmodule

// File: rtl/bcd_carry_chain.sv
module bcd_carry_chain
  import bcd_add_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic [DIGITS-1:0] gen_i,
  input  logic [DIGITS-1:0] prop_i,
  input  logic              cin_i,
  output logic [DIGITS:0]   carry_o
);
  assign carry_o[0] = cin_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_stage
    assign carry_o[k+1] = maj3(gen_i[k], prop_i[k], carry_o[k]);

    always_comb begin
      if (!$isunknown({gen_i[k], prop_i[k], cin_i})) begin
        p_gen_forces_r5: assert (!gen_i[k] || carry_o[k+1])
          else $error("generate did not force carry");
        p_noprop_kills_r5: assert (prop_i[k] || !carry_o[k+1])
          else $error("carry without propagate");
        p_gen_in_prop_r4: assert (!gen_i[k] || prop_i[k])
          else $error("generate without propagate");
      end
    end
  end
endmodule

// File: rtl/bcd_digit_post.sv
module bcd_digit_post
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] bsum_i,
  input  logic               dcarry_i,
  input  logic               cin_i,
  output logic [DIGIT_W-1:0] digit_o
);
  logic [DIGIT_W-1:0] corr;

  assign corr    = {1'b0, dcarry_i, dcarry_i, 1'b0};
  assign digit_o = bsum_i + corr + {{(DIGIT_W-1){1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({bsum_i, dcarry_i, cin_i})) begin
      p_corr_apply_r6: assert (((digit_o - bsum_i - {3'b0, cin_i}) & 4'hF) ==
                               (dcarry_i ? 4'd6 : 4'd0))
        else $error("correction word wrong");
    end
  end
endmodule

// File: rtl/bcd_par_adder.sv
module bcd_par_adder
  import bcd_add_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic [DIGIT_W*DIGITS-1:0] a_i,
  input  logic [DIGIT_W*DIGITS-1:0] b_i,
  input  logic                      cin_i,
  output logic [DIGIT_W*DIGITS-1:0] sum_o,
  output logic                      cout_o
);
  localparam int unsigned W = DIGIT_W * DIGITS;

  logic [W-1:0]      bsum;
  logic [DIGITS-1:0] gen;
  logic [DIGITS-1:0] prop;
  logic [DIGITS:0]   carry;

  for (genvar k = 0; k < DIGITS; k++) begin : g_pre
    bcd_digit_pre i_pre (
      .a_i    (a_i[DIGIT_W*k +: DIGIT_W]),
      .b_i    (b_i[DIGIT_W*k +: DIGIT_W]),
      .bsum_o (bsum[DIGIT_W*k +: DIGIT_W]),
      .gen_o  (gen[k]),
      .prop_o (prop[k])
    );
  end

  bcd_carry_chain #(.DIGITS(DIGITS)) i_chain (
    .gen_i   (gen),
    .prop_i  (prop),
    .cin_i   (cin_i),
    .carry_o (carry)
  );

  for (genvar k = 0; k < DIGITS; k++) begin : g_post
    bcd_digit_post i_post (
      .bsum_i   (bsum[DIGIT_W*k +: DIGIT_W]),
      .dcarry_i (carry[k+1]),
      .cin_i    (carry[k]),
      .digit_o  (sum_o[DIGIT_W*k +: DIGIT_W])
    );

    always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
        p_digit_carry_r5: assert (carry[k+1] ==
            (({1'b0, a_i[DIGIT_W*k +: DIGIT_W]} + {1'b0, b_i[DIGIT_W*k +: DIGIT_W]}
              + {4'b0, carry[k]}) >= 5'd10))
          else $error("digit carry mismatch");
        if (a_i[DIGIT_W*k +: DIGIT_W] < 4'd10 && b_i[DIGIT_W*k +: DIGIT_W] < 4'd10) begin
          p_digit_valid_r7: assert (sum_o[DIGIT_W*k +: DIGIT_W] < 4'd10)
            else $error("sum digit not BCD");
        end
      end
    end
  end

  assign cout_o = carry[DIGITS];

  always_comb begin
    if (!$isunknown(cin_i)) begin
      p_cin_entry_r8: assert (carry[0] == cin_i) else $error("carry-in lost");
    end
  end
endmodule

// File: tb/test_bcd_par_adder.sv
module test_bcd_par_adder;
  localparam int unsigned DIGITS     = 8;
  localparam int unsigned W          = 4 * DIGITS;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_RAND     = 400;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_checks = 0;
  int           n_errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_par_adder #(.DIGITS(DIGITS)) i_bcd_par_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  function automatic longint bcd2int(input logic [W-1:0] v);
    longint r = 0;
    for (int k = DIGITS - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] int2bcd(input longint v);
    logic [W-1:0] r = '0;
    longint t = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint modulus();
    longint m = 1;
    for (int k = 0; k < DIGITS; k++) m = m * 10;
    return m;
  endfunction

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] r;
    for (int k = 0; k < DIGITS; k++) r[4*k +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic check_vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                           input logic vc, input string tag);
    longint tot;
    logic [W-1:0] exp_sum;
    logic exp_cout;
    bit valid;
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
    tot      = bcd2int(va) + bcd2int(vb) + longint'(vc);
    exp_cout = (tot >= modulus());
    exp_sum  = int2bcd(tot % modulus());
    n_checks++;
    if (sum !== exp_sum) begin
      n_errors++;
      $display("FAIL R1 %s: sum act=%h exp=%h", tag, sum, exp_sum);
    end
    n_checks++;
    if (cout !== exp_cout) begin
      n_errors++;
      $display("FAIL R2 %s: cout act=%b exp=%b", tag, cout, exp_cout);
    end
    valid = 1'b1;
    for (int k = 0; k < DIGITS; k++) if (sum[4*k +: 4] > 4'd9) valid = 1'b0;
    n_checks++;
    if (!valid) begin
      n_errors++;
      $display("FAIL R7 %s: sum act=%h exp=all digits 0..9", tag, sum);
    end
  endtask

  initial begin
    logic [W-1:0] nines, fives, fours, ones;
    void'($urandom(32'd1234));
    nines = {DIGITS{4'h9}};
    fives = {DIGITS{4'h5}};
    fours = {DIGITS{4'h4}};
    ones  = {{(DIGITS-1){4'h0}}, 4'h1};
    a = '0; b = '0; cin = 1'b0;

    check_vec('0, '0, 1'b0, "zero operands");           // R1 R2 idle state
    check_vec(nines, '0, 1'b1, "all 9s + cin");         // R8 full propagation
    check_vec(nines, '0, 1'b0, "all 9s no cin");        // R4 R5 propagate alone
    check_vec(nines, ones, 1'b0, "all 9s + 1");         // R8
    check_vec(nines, nines, 1'b1, "9+9 binary carry");  // R3 R6
    check_vec(fives, fives, 1'b0, "5+5 generate");      // R3 R6
    check_vec(fours, fives, 1'b0, "4+5 no cin");        // R4 R5
    check_vec(fours, fives, 1'b1, "4+5 with cin");      // R4 R5 R8
    check_vec({(DIGITS/2){8'h90}}, {(DIGITS/2){8'h09}}, 1'b1, "alternating"); // R5

    // R9: outputs follow a change without any clock edge
    a = nines; b = '0; cin = 1'b0;
    #1;
    cin = 1'b1;
    #1;
    n_checks++;
    if (sum !== '0 || cout !== 1'b1) begin
      n_errors++;
      $display("FAIL R9 async update: sum=%h cout=%b exp sum=0 cout=1", sum, cout);
    end

    for (int i = 0; i < N_RAND; i++)
      check_vec(rand_bcd(), rand_bcd(), 1'($urandom % 2), "random");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule